// File: doc/BRIEF.md
# DRAM Command Bus Stretch Driver

This block sits between a memory scheduler and the DRAM command and address pins. The scheduler offers one command per cycle with a valid flag. The block places each accepted command on the bus and keeps it there for one, two or three DRAM clocks. A 2-bit timing mode picks the length. The chip-select line of the target rank is raised only in the last of those clocks, so the devices sample the command when the address and command lines have had time to settle. A ready signal tells the scheduler when the next command can be taken.

A policy bit sets what the bus does between commands.
- With the policy bit clear, the block drives the bus only while the channel is in use. The channel is in use while a hold window is open, or while at least one rank has clock enable high and is not in self-refresh. The block releases the bus once every rank is powered down or self-refreshing.
- With the policy bit set, the bus is always driven, and the last accepted command and address stay on the lines.

The mode and the policy bit are sampled only when the block is ready. A change made in the middle of a hold window therefore never alters that window.

Top module: `cmd_stretch_drv`

## Requirements
- R1: During reset, ready_o is 1, cs_o is all zero and bus_cmd_o and bus_addr_o are zero.
- R2: The hold window length N follows the registered mode: 2'b00 gives 1, 2'b10 gives 2 and 2'b11 gives 3. The window starts in the cycle after the accepting edge, so chip select appears at the N-th cycle after acceptance.
- R3: The registered mode resets to 2'b10. A command accepted at the first edge after reset is held for 2 cycles, whatever mode_i shows at that edge.
- R4: cs_o is one-hot with bit rank_i (as accepted) set, and only in the last cycle of a window. It is zero at all other times, so there is exactly one pulse per accepted command.
- R5: bus_cmd_o and bus_addr_o take the accepted command and address after the accepting edge. They stay stable until the next accepted command.
- R6: ready_o is 0 in every cycle of a window except the last, and 1 otherwise. A command offered while ready_o is 0 is ignored.
- R7: With the registered policy at 0, oe_o is 1 while a window is open or while any rank has cke_i=1 and sref_i=0. Otherwise oe_o is 0.
- R8: With the registered policy at 1, oe_o is always 1. When idle, the bus keeps repeating the last accepted command and address.
- R9: mode_i and drive_always_i are registered only at edges where ready_o is 1, so a change during a window does not alter the current window.
- R10: The registered policy resets to 0. During reset, oe_o is 0 when no rank is active, even with drive_always_i=1.
- R11: The reserved mode 2'b01 behaves as 2'b00 (N=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted synchronously to clk |
| mode_i | input | 2 | Hold timing: 00 one clock, 01 reserved (one clock), 10 two clocks, 11 three clocks |
| drive_always_i | input | 1 | 1: bus always driven; 0: bus released when the channel is idle |
| cmd_valid_i | input | 1 | Scheduler offers a command this cycle |
| cmd_i | input | CMD_W | Command code lines |
| addr_i | input | ADDR_W | Address lines |
| rank_i | input | RANK_W | Target rank index |
| cke_i | input | NUM_RANKS | Per-rank clock-enable status |
| sref_i | input | NUM_RANKS | Per-rank self-refresh (or deeper) status |
| bus_cmd_o | output | CMD_W | Command lines to the pads |
| bus_addr_o | output | ADDR_W | Address lines to the pads |
| cs_o | output | NUM_RANKS | Active-high one-hot chip select |
| oe_o | output | 1 | Output enable for the command and address pads |
| ready_o | output | 1 | Block can accept a command at the next edge |

## Verification
The bench builds the block with NUM_RANKS=4 and ADDR_W=12. Four ranks exercise every chip-select bit, and a 2-bit rank index with rank mixes where only some ranks are powered up. With CMD_W=3 and 12 address bits, random commands seldom repeat, so a lost or duplicated acceptance shows up as a wrong value held on the bus. Random traffic covers all four mode codes, both policies, and mode changes inside windows. Directed cases measure the window length for each code, the reset mode and the policy state during reset.

// File: rtl/cmdstr_pkg.sv
package cmdstr_pkg;

  typedef enum logic [1:0] {
    MODE_1N  = 2'b00,
    MODE_RSV = 2'b01,
    MODE_2N  = 2'b10,
    MODE_3N  = 2'b11
  } cmd_mode_e;

  localparam int unsigned HOLD_CNT_W = 2;

  // Number of extra clocks beyond the first one that a command stays on the bus.
  function automatic logic [HOLD_CNT_W-1:0] hold_extra(cmd_mode_e m);
    case (m)
      MODE_2N: hold_extra = 2'd1;
      MODE_3N: hold_extra = 2'd2;
      default: hold_extra = 2'd0;  // 1N and the reserved code
    endcase
  endfunction

endpackage

// File: rtl/cmdstr_cfg.sv
module cmdstr_cfg
  import cmdstr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  logic [1:0] mode_i,
  input  logic      policy_i,
  output cmd_mode_e mode_q,
  output logic      policy_q
);

  cmd_mode_e mode_d;
  logic      policy_d;

  always_comb begin
    mode_d   = mode_q;
    policy_d = policy_q;
    if (load_en) begin
      mode_d   = cmd_mode_e'(mode_i);
      policy_d = policy_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_2N;
      policy_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      policy_q <= policy_d;
    end
  end

endmodule

// File: rtl/cmdstr_hold.sv
module cmdstr_hold
  import cmdstr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [HOLD_CNT_W-1:0] start_extra,
  output logic                  busy,
  output logic                  last
);

  logic                  busy_q, busy_d;
  logic [HOLD_CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = start_extra;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign last = busy_q && (cnt_q == '0);

endmodule

// File: rtl/cmdstr_oe.sv
module cmdstr_oe #(
  parameter int NUM_RANKS = 2
) (
  input  logic                 policy,
  input  logic                 busy,
  input  logic [NUM_RANKS-1:0] cke,
  input  logic [NUM_RANKS-1:0] sref,
  output logic                 oe
);

  logic chan_active;

  always_comb begin
    chan_active = |(cke & ~sref);
    oe          = policy | busy | chan_active;
  end

endmodule

// File: rtl/cmd_stretch_drv.sv
module cmd_stretch_drv
  import cmdstr_pkg::*;
#(
  parameter  int CMD_W     = 3,
  parameter  int ADDR_W    = 16,
  parameter  int NUM_RANKS = 2,
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic                 drive_always_i,
  input  logic                 cmd_valid_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [RANK_W-1:0]    rank_i,
  input  logic [NUM_RANKS-1:0] cke_i,
  input  logic [NUM_RANKS-1:0] sref_i,
  output logic [CMD_W-1:0]     bus_cmd_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic [NUM_RANKS-1:0] cs_o,
  output logic                 oe_o,
  output logic                 ready_o
);

  cmd_mode_e mode_q;
  logic      policy_q;
  logic      busy, last, accept;

  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [RANK_W-1:0] rank_q, rank_d;

  // A new command may enter at the edge that closes the current window.
  assign ready_o = !busy || last;
  assign accept  = cmd_valid_i && ready_o;

  cmdstr_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ready_o),
    .mode_i   (mode_i),
    .policy_i (drive_always_i),
    .mode_q   (mode_q),
    .policy_q (policy_q)
  );

  cmdstr_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_extra (hold_extra(mode_q)),
    .busy        (busy),
    .last        (last)
  );

  // Command and address registers: clock enable is the accept strobe.
  always_comb begin
    cmd_d  = cmd_q;
    addr_d = addr_q;
    rank_d = rank_q;
    if (accept) begin
      cmd_d  = cmd_i;
      addr_d = addr_i;
      rank_d = rank_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      rank_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      rank_q <= rank_d;
    end
  end

  assign bus_cmd_o  = cmd_q;
  assign bus_addr_o = addr_q;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_cs
    assign cs_o[r] = last && (rank_q == RANK_W'(r));
  end

  cmdstr_oe #(.NUM_RANKS(NUM_RANKS)) u_oe (
    .policy (policy_q),
    .busy   (busy),
    .cke    (cke_i),
    .sref   (sref_i),
    .oe     (oe_o)
  );

endmodule

// File: rtl/cmdstr_chk.sv
module cmdstr_chk #(
  parameter int CMD_W     = 3,
  parameter int ADDR_W    = 16,
  parameter int NUM_RANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid_i,
  input logic [NUM_RANKS-1:0] cke_i,
  input logic [NUM_RANKS-1:0] sref_i,
  input logic [CMD_W-1:0]     bus_cmd_o,
  input logic [ADDR_W-1:0]    bus_addr_o,
  input logic [NUM_RANKS-1:0] cs_o,
  input logic                 oe_o,
  input logic                 ready_o
);

  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  assert_cs_final_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs_o) |-> ready_o);

  assert_bus_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o || !cmd_valid_i) |=> ($stable(bus_cmd_o) && $stable(bus_addr_o)));

  assert_oe_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cke_i & ~sref_i)) |-> oe_o);

  assert_oe_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> oe_o);

endmodule

bind cmd_stretch_drv cmdstr_chk #(
  .CMD_W(CMD_W), .ADDR_W(ADDR_W), .NUM_RANKS(NUM_RANKS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_i (cmd_valid_i),
  .cke_i       (cke_i),
  .sref_i      (sref_i),
  .bus_cmd_o   (bus_cmd_o),
  .bus_addr_o  (bus_addr_o),
  .cs_o        (cs_o),
  .oe_o        (oe_o),
  .ready_o     (ready_o)
);

// File: tb/cmd_stretch_drv_bench.sv
`timescale 1ns/1ps
module cmd_stretch_drv_bench;

  localparam int CW = 3;
  localparam int AW = 12;
  localparam int NR = 4;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          pol;
  logic          valid;
  logic [CW-1:0] cmd;
  logic [AW-1:0] addr;
  logic [RW-1:0] rank;
  logic [NR-1:0] cke, sref;
  logic [CW-1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [NR-1:0] cs;
  logic          oe, ready;

  int checks = 0;
  int errors = 0;
  bit mon_en = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmd_stretch_drv #(.CMD_W(CW), .ADDR_W(AW), .NUM_RANKS(NR)) u_cmd_stretch_drv (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .drive_always_i(pol),
    .cmd_valid_i(valid), .cmd_i(cmd), .addr_i(addr), .rank_i(rank),
    .cke_i(cke), .sref_i(sref), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .cs_o(cs), .oe_o(oe), .ready_o(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input logic [1:0] m);
    case (m)
      2'b10:   return 2;
      2'b11:   return 3;
      default: return 1;
    endcase
  endfunction

  // Reference model built from the requirements
  bit            m_busy;
  int            m_left;
  logic [CW-1:0] m_cmd;
  logic [AW-1:0] m_addr;
  logic [RW-1:0] m_rank;
  logic [1:0]    m_mode;
  bit            m_pol;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_left = 0; m_cmd = '0; m_addr = '0; m_rank = '0;
      m_mode = 2'b10; m_pol = 0;
    end else begin
      bit rdy, acc;
      logic [1:0] old_mode;
      rdy = !m_busy || (m_left == 0);
      acc = valid && rdy;
      old_mode = m_mode;
      if (rdy) begin
        m_mode = mode;
        m_pol  = pol;
      end
      if (acc) begin
        m_cmd = cmd; m_addr = addr; m_rank = rank;
        m_busy = 1; m_left = exp_len(old_mode) - 1;
      end else if (m_busy) begin
        if (m_left == 0) m_busy = 0;
        else m_left = m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      bit last;
      logic [NR-1:0] ecs;
      last = m_busy && (m_left == 0);
      ecs  = last ? (NR'(1) << m_rank) : '0;
      chk("R6 ready", 32'(ready), 32'(!m_busy || last));
      chk("R4 cs", 32'(cs), 32'(ecs));
      if (m_pol) chk("R8 oe", 32'(oe), 32'(1));
      else       chk("R7 oe", 32'(oe), 32'(m_busy || (|(cke & ~sref))));
      chk("R5 bus_cmd", 32'(bus_cmd), 32'(m_cmd));
      chk("R5 bus_addr", 32'(bus_addr), 32'(m_addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Offer one command while idle and return the cycle index of the cs pulse.
  task automatic measure(input logic [1:0] md, output int len, input bit chg, input logic [1:0] md2);
    valid = 0; mode = md;
    repeat (4) step();
    valid = 1; cmd = CW'($urandom); addr = AW'($urandom); rank = RW'($urandom);
    step();
    valid = 0;
    if (chg) mode = md2;
    len = 0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (|cs && len == 0) len = k;
    end
  endtask

  initial begin
    int len;
    void'($urandom(32'd1234));
    rst_n = 0; mode = 2'b00; pol = 1; valid = 1; cmd = 3'd5; addr = 12'h3a5;
    rank = 2'd2; cke = '0; sref = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(ready), 32'(1));
    chk("R1 cs", 32'(cs), 32'(0));
    chk("R1 bus", 32'({bus_cmd, bus_addr}), 32'(0));
    chk("R10 oe", 32'(oe), 32'(0));
    // R3: first accept after reset uses 2N although mode_i is 00
    @(posedge clk); #1; rst_n = 1;
    step(); valid = 0;
    len = 0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (|cs && len == 0) len = k;
    end
    chk("R3 reset mode length", 32'(len), 32'(2));
    chk("R3 bus_cmd", 32'(bus_cmd), 32'(5));
    mon_en = 1;
    pol = 0; cke = 4'b0011;
    measure(2'b00, len, 0, 2'b00); chk("R2 1N length", 32'(len), 32'(1));
    measure(2'b10, len, 0, 2'b00); chk("R2 2N length", 32'(len), 32'(2));
    measure(2'b11, len, 0, 2'b00); chk("R2 3N length", 32'(len), 32'(3));
    measure(2'b01, len, 0, 2'b00); chk("R11 reserved length", 32'(len), 32'(1));
    measure(2'b11, len, 1, 2'b00); chk("R9 mid-window change", 32'(len), 32'(3));
    // mode now 00 registered at the window's last edge
    valid = 1; cmd = 3'd2; step(); valid = 0;
    len = 0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (|cs && len == 0) len = k;
    end
    chk("R9 new mode after window", 32'(len), 32'(1));
    // R7: all ranks down, idle -> released
    cke = 4'b0101; sref = 4'b0101; repeat (3) step();
    @(negedge clk); chk("R7 released", 32'(oe), 32'(0));
    // R8: always drive, idle repeats last command
    pol = 1; repeat (3) step();
    @(negedge clk);
    chk("R8 oe idle", 32'(oe), 32'(1));
    chk("R8 repeat", 32'(bus_cmd), 32'(2));
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      step();
      valid = ($urandom_range(0, 1) == 1);
      cmd = CW'($urandom); addr = AW'($urandom); rank = RW'($urandom);
      if ($urandom_range(0, 7) == 0) mode = 2'($urandom);
      if ($urandom_range(0, 31) == 0) pol = ~pol;
      if ($urandom_range(0, 15) == 0) begin
        cke = NR'($urandom); sref = NR'($urandom);
      end
    end
    step(); valid = 0; repeat (4) step();
    mon_en = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule